// File: doc/BRIEF.md
# Disciplined Mission Elapsed Time Counter

This block keeps spacecraft elapsed time as a seconds count and a microsecond sub-second count. Each clock cycle of the local reference is one nominal microsecond. Three corrections can be applied to it. A coarse load replaces the whole time value in one step. A fine correction moves a signed number of microseconds into the count gradually, at most one microsecond per slew interval, so that time never jumps. A drift trim adds or removes one microsecond every programmed number of cycles, and keeps doing so until it is changed.

Software reaches the block through a simple register port. It has one write strobe and one read strobe, each with a 3-bit address. Reading the sub-second word latches the seconds word, so a following read of the seconds word belongs to the same instant. Two further registers hold a correlation offset and a leap-second count. They are stored and read back and have no effect on the count.

A small state machine runs the fine correction. It has three states. ST_IDLE means no correction is pending. ST_ADVANCE means the remaining amount is positive, and a microsecond is inserted each time the slew interval expires. ST_RETARD means the remaining amount is negative, and a microsecond is withheld each time the interval expires. The transitions are:
- arm-positive: ST_IDLE, ST_ADVANCE or ST_RETARD to ST_ADVANCE.
- arm-negative: any state to ST_RETARD.
- arm-zero: any state to ST_IDLE.
- drain: ST_ADVANCE or ST_RETARD to ST_IDLE, when the last microsecond has been applied.
- cancel: any state to ST_IDLE, on a coarse load.
- hold: stays in ST_RETARD for one more cycle when a drift skip falls on the same cycle.

Top module: `mtm_top`

## Requirements
- R1: After reset, the seconds and sub-second counts are 0. Every register reads 0, and rd_data is 0.
- R2: Without corrections, time_sub advances by one each cycle. When time_sub is US_PER_SEC-1, it wraps to 0 and time_sec increments.
- R3: A write to address 1 loads time_sec with the written data and time_sub with the staged sub-second value. Both appear in the next cycle. The write also cancels any pending fine correction, so address 2 then reads 0.
- R4: A write to address 0 stores the staged sub-second value if the data is below US_PER_SEC. A larger value is ignored. Address 6 reads back the staged value.
- R5: A write to address 2 arms a signed, two's-complement microsecond amount. While the amount is nonzero, the count advances by one extra (positive) or one less (negative) in the SLEW_INT-th cycle after arming, and again every SLEW_INT cycles after that. Each step moves the remaining amount one toward zero, and there is never more than one step per SLEW_INT cycles.
- R6: A write to address 2 while a correction is in progress replaces the remaining amount and restarts the slew interval.
- R7: A nonzero signed drift period P written to address 3 adds one microsecond (P>0) or skips one (P<0) once every max(|P|,2) cycles, counted from the write. P=0 disables the trim. Address 3 reads back P.
- R8: When a fine skip and a drift skip fall in the same cycle, the fine skip moves to the next cycle. The count therefore never advances by less than 0 microseconds per cycle.
- R9: rd_en returns the addressed register on rd_data in the next cycle. rd_data holds its value otherwise. A read of address 0 returns time_sub zero-extended and latches time_sec, and address 1 reads that latched value.
- R10: Address 4 (correlation offset) and address 5 (leap seconds) store the written data and read it back. They do not affect the count.
- R11: Address 2 reads the remaining fine amount. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one nominal microsecond per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Read data, registered |
| time_sec | output | SEC_W | Seconds count |
| time_sub | output | SUB_W | Microseconds within the second |

## Verification
The bench builds the block with US_PER_SEC=1000 and SLEW_INT=10, instead of a million and ten thousand. This puts many second rollovers, whole fine corrections and repeated re-arms within a few thousand cycles. The short slew interval also makes fine steps coincide often with drift periods of 2 to 9 cycles. These coincidences include the deferred skip, and the bench compares the count against its model in every cycle.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADVANCE,
        ST_RETARD
    } slew_state_t;

    localparam logic [2:0] A_SUB   = 3'd0;
    localparam logic [2:0] A_SEC   = 3'd1;
    localparam logic [2:0] A_FINE  = 3'd2;
    localparam logic [2:0] A_TRIM  = 3'd3;
    localparam logic [2:0] A_OFFS  = 3'd4;
    localparam logic [2:0] A_LEAP  = 3'd5;
    localparam logic [2:0] A_STAGE = 3'd6;

endpackage

// File: rtl/mtm_slew.sv
module mtm_slew
    import mtm_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SLEW_INT = 10_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [DW-1:0] arm_val,
    input  logic          cancel,
    input  logic          drift_drop,
    output logic          f_add,
    output logic          f_drop,
    output logic [DW-1:0] remaining
);

    localparam int CW = (SLEW_INT > 1) ? $clog2(SLEW_INT) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLEW_INT - 1);

    slew_state_t   state, state_nx;
    logic [DW-1:0] rem_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          due, hold, fire;

    // interval expiry, and the deferral when a drift skip coincides
    always_comb begin
        due  = (state != ST_IDLE) && (cnt == LAST);
        hold = due && (state == ST_RETARD) && drift_drop;
        fire = due && !hold;
    end

    // outputs
    always_comb begin
        f_add  = fire && (state == ST_ADVANCE);
        f_drop = fire && (state == ST_RETARD);
    end

    // next state
    always_comb begin
        state_nx = state;
        rem_nx   = remaining;
        cnt_nx   = cnt;
        if (cancel) begin
            state_nx = ST_IDLE;
            rem_nx   = '0;
            cnt_nx   = '0;
        end else if (arm) begin
            rem_nx = arm_val;
            cnt_nx = '0;
            if (arm_val == '0)
                state_nx = ST_IDLE;
            else if (arm_val[DW-1])
                state_nx = ST_RETARD;
            else
                state_nx = ST_ADVANCE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nx = '0;
                end
                ST_ADVANCE: begin
                    if (fire) begin
                        rem_nx = remaining - DW'(1);
                        cnt_nx = '0;
                        if (remaining == DW'(1))
                            state_nx = ST_IDLE;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                ST_RETARD: begin
                    if (fire) begin
                        rem_nx = remaining + DW'(1);
                        cnt_nx = '0;
                        if (remaining == '1)
                            state_nx = ST_IDLE;
                    end else if (!hold) begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    rem_nx   = '0;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            cnt       <= '0;
        end else begin
            state     <= state_nx;
            remaining <= rem_nx;
            cnt       <= cnt_nx;
        end
    end

endmodule

// File: rtl/mtm_trim.sv
module mtm_trim #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          d_add,
    output logic          d_drop,
    output logic [DW-1:0] period
);

    logic [DW-1:0] cnt, mag, eff;
    logic          due;

    always_comb begin
        mag    = period[DW-1] ? (~period + DW'(1)) : period;
        eff    = (mag < DW'(2)) ? DW'(2) : mag;
        due    = (period != '0) && (cnt == eff - DW'(1));
        d_add  = due && !period[DW-1];
        d_drop = due && period[DW-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '0;
            cnt    <= '0;
        end else if (load) begin
            period <= load_val;
            cnt    <= '0;
        end else if (period != '0) begin
            cnt <= due ? '0 : cnt + DW'(1);
        end
    end

endmodule

// File: rtl/mtm_count.sv
module mtm_count #(
    parameter int SEC_W      = 32,
    parameter int US_PER_SEC = 1_000_000,
    parameter int SUB_W      = $clog2(US_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [SUB_W-1:0] load_sub,
    input  logic [1:0]       inc,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub
);

    localparam logic [SUB_W:0] WRAP = (SUB_W + 1)'(US_PER_SEC);

    logic [SUB_W:0] sum;

    always_comb sum = {1'b0, sub} + {{(SUB_W - 1){1'b0}}, inc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= '0;
            sub <= '0;
        end else if (load) begin
            sec <= load_sec;
            sub <= load_sub;
        end else if (sum >= WRAP) begin
            sub <= SUB_W'(sum - WRAP);
            sec <= sec + SEC_W'(1);
        end else begin
            sub <= sum[SUB_W-1:0];
        end
    end

endmodule

// File: rtl/mtm_top.sv
module mtm_top
    import mtm_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int US_PER_SEC = 1_000_000,
    parameter int SLEW_INT   = 10_000,
    parameter int DW         = 32,
    localparam int SUB_W     = $clog2(US_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [SEC_W-1:0] time_sec,
    output logic [SUB_W-1:0] time_sub
);

    logic             coarse_ld, fine_arm, trim_ld;
    logic             f_add, f_drop, d_add, d_drop;
    logic [1:0]       inc;
    logic [DW-1:0]    fine_rem, trim_per;
    logic [SUB_W-1:0] stage;
    logic [SEC_W-1:0] shadow;
    logic [DW-1:0]    offs_q, leap_q, rd_mux;

    always_comb begin
        coarse_ld = wr_en && (wr_addr == A_SEC);
        fine_arm  = wr_en && (wr_addr == A_FINE);
        trim_ld   = wr_en && (wr_addr == A_TRIM);
        inc = 2'd1 + 2'(f_add) + 2'(d_add) - 2'(f_drop) - 2'(d_drop);
    end

    mtm_slew #(.DW(DW), .SLEW_INT(SLEW_INT)) u_slew (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (fine_arm),
        .arm_val    (wr_data),
        .cancel     (coarse_ld),
        .drift_drop (d_drop),
        .f_add      (f_add),
        .f_drop     (f_drop),
        .remaining  (fine_rem)
    );

    mtm_trim #(.DW(DW)) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trim_ld),
        .load_val (wr_data),
        .d_add    (d_add),
        .d_drop   (d_drop),
        .period   (trim_per)
    );

    mtm_count #(.SEC_W(SEC_W), .US_PER_SEC(US_PER_SEC), .SUB_W(SUB_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (coarse_ld),
        .load_sec (wr_data[SEC_W-1:0]),
        .load_sub (stage),
        .inc      (inc),
        .sec      (time_sec),
        .sub      (time_sub)
    );

    // stored registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage  <= '0;
            offs_q <= '0;
            leap_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_SUB:   if (wr_data < DW'(US_PER_SEC)) stage <= wr_data[SUB_W-1:0];
                A_OFFS:  offs_q <= wr_data;
                A_LEAP:  leap_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_SUB:   rd_mux = DW'(time_sub);
            A_SEC:   rd_mux = DW'(shadow);
            A_FINE:  rd_mux = fine_rem;
            A_TRIM:  rd_mux = trim_per;
            A_OFFS:  rd_mux = offs_q;
            A_LEAP:  rd_mux = leap_q;
            A_STAGE: rd_mux = DW'(stage);
            default: rd_mux = '0;
        endcase
    end

    // read port: low word latches the high word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            shadow  <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
            if (rd_addr == A_SUB)
                shadow <= time_sec;
        end
    end

endmodule

// File: rtl/mtm_chk.sv
module mtm_chk #(
    parameter int SEC_W    = 32,
    parameter int SUB_W    = 20,
    parameter int SLEW_INT = 10_000,
    parameter int DW       = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEC_W-1:0] time_sec,
    input logic [SUB_W-1:0] time_sub,
    input logic             coarse_ld,
    input logic             fine_arm,
    input logic             f_add,
    input logic             f_drop,
    input logic             d_drop,
    input logic [DW-1:0]    fine_rem,
    input logic             rd_en,
    input logic [DW-1:0]    rd_data
);

    logic [31:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap <= '0;
        else if (fine_arm || coarse_ld || f_add || f_drop)
            gap <= '0;
        else if (gap != '1)
            gap <= gap + 32'd1;
    end

    a_r2_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(coarse_ld) |->
            ((time_sub >= $past(time_sub)) ? (time_sec == $past(time_sec))
                                           : (time_sec == SEC_W'($past(time_sec) + SEC_W'(1)))));

    a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_ld |=> (fine_rem == '0));

    a_r5_rate_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (f_add || f_drop) |-> (gap >= 32'(SLEW_INT - 1)));

    a_r5_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (f_add && !fine_arm && !coarse_ld) |=> (fine_rem == $past(fine_rem) - DW'(1)));

    a_r8_single_skip: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_drop && d_drop));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind mtm_top mtm_chk #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .SLEW_INT(SLEW_INT), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_sec  (time_sec),
    .time_sub  (time_sub),
    .coarse_ld (coarse_ld),
    .fine_arm  (fine_arm),
    .f_add     (f_add),
    .f_drop    (f_drop),
    .d_drop    (d_drop),
    .fine_rem  (fine_rem),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
);

// File: tb/mtm_top_tb.sv
module mtm_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int US_PS      = 1000;
    localparam int SI         = 10;
    localparam int SUB_W      = $clog2(US_PS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic             rd_en = 1'b0;
    logic [2:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic [31:0]      time_sec;
    logic [SUB_W-1:0] time_sub;

    int checks = 0;
    int failures = 0;
    string cur_req = "R2";

    // model state
    logic [31:0] m_sec = '0, m_shadow = '0, exp_rd = '0;
    int m_sub = 0, m_stage = 0, m_scnt = 0, m_dcnt = 0;
    int m_rem = 0, m_dper = 0;
    logic [31:0] m_off = '0, m_leap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtm_top #(.SEC_W(32), .US_PER_SEC(US_PS), .SLEW_INT(SI), .DW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .time_sec(time_sec), .time_sub(time_sub)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_period(input int p);
        int mag = (p < 0) ? -p : p;
        return (mag < 2) ? 2 : mag;
    endfunction

    task automatic model_step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                              input logic re, input logic [2:0] ra);
        int dadd = 0, ddrop = 0, fadd = 0, fdrop = 0, nsub;
        if (re) begin
            case (ra)
                3'd0: begin exp_rd = 32'(m_sub); m_shadow = m_sec; end
                3'd1: exp_rd = m_shadow;
                3'd2: exp_rd = 32'(m_rem);
                3'd3: exp_rd = 32'(m_dper);
                3'd4: exp_rd = m_off;
                3'd5: exp_rd = m_leap;
                3'd6: exp_rd = 32'(m_stage);
                default: exp_rd = '0;
            endcase
        end
        if (m_dper != 0) begin
            if (m_dcnt == eff_period(m_dper) - 1) begin
                if (m_dper < 0) ddrop = 1; else dadd = 1;
                m_dcnt = 0;
            end else m_dcnt++;
        end
        if (m_rem != 0) begin
            if (m_scnt == SI - 1) begin
                if (!(m_rem < 0 && ddrop == 1)) begin
                    if (m_rem > 0) begin fadd = 1; m_rem--; end
                    else begin fdrop = 1; m_rem++; end
                    m_scnt = 0;
                end
            end else m_scnt++;
        end
        nsub = m_sub + 1 + fadd + dadd - fdrop - ddrop;
        if (nsub >= US_PS) begin nsub -= US_PS; m_sec = m_sec + 1; end
        m_sub = nsub;
        if (we) begin
            case (wa)
                3'd0: if (wd < 32'(US_PS)) m_stage = int'(wd);
                3'd1: begin m_sec = wd; m_sub = m_stage; m_rem = 0; m_scnt = 0; end
                3'd2: begin m_rem = int'(wd); m_scnt = 0; end
                3'd3: begin m_dper = int'(wd); m_dcnt = 0; end
                3'd4: m_off = wd;
                3'd5: m_leap = wd;
                default: ;
            endcase
        end
    endtask

    task automatic tick(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                        input logic re, input logic [2:0] ra);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        model_step(we, wa, wd, re, ra);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk({cur_req, " time_sub"}, 32'(time_sub), 32'(m_sub));
        chk({cur_req, " time_sec"}, time_sec, m_sec);
        if (re) chk({cur_req, " rd_data"}, rd_data, exp_rd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 3'd0, '0, 1'b0, 3'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        tick(1'b1, a, d, 1'b0, 3'd0);
    endtask

    task automatic rd(input logic [2:0] a);
        tick(1'b0, 3'd0, '0, 1'b1, a);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1 reset time_sub", 32'(time_sub), 0);
        chk("R1 reset time_sec", time_sec, 0);
        chk("R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a));   // R1 and R11: all registers zero

        cur_req = "R4";
        wr(3'd0, 32'd995);
        wr(3'd0, 32'd1000);                      // ignored
        rd(3'd6);
        chk("R4 stage kept", rd_data, 32'd995);

        cur_req = "R3";
        wr(3'd1, 32'd7);
        cur_req = "R2";
        idle(12);                                // rollover after coarse load

        cur_req = "R9";
        while (m_sub != US_PS - 1) idle(1);
        rd(3'd0);
        rd(3'd1);
        chk("R9 latched seconds", rd_data, m_sec - 1);

        cur_req = "R5";
        wr(3'd2, 32'd3);
        idle(45);
        rd(3'd2);
        chk("R5 drained", rd_data, 0);
        wr(3'd2, -32'sd4);
        idle(25);
        rd(3'd2);

        cur_req = "R6";
        idle(5);
        wr(3'd2, 32'd6);
        idle(15);
        rd(3'd2);

        cur_req = "R3";
        wr(3'd1, 32'd100);
        rd(3'd2);
        chk("R3 cancel", rd_data, 0);

        cur_req = "R7";
        wr(3'd3, 32'd3);
        idle(20);
        wr(3'd3, -32'sd1);
        idle(20);
        rd(3'd3);
        wr(3'd3, 32'd0);
        idle(10);

        cur_req = "R8";
        wr(3'd3, -32'sd2);
        wr(3'd2, -32'sd3);
        idle(50);
        rd(3'd2);
        wr(3'd3, 32'd0);

        cur_req = "R10";
        wr(3'd4, 32'hCAFE_0123);
        wr(3'd5, 32'd37);
        rd(3'd4);
        rd(3'd5);
        idle(3);
        rd(3'd7);

        cur_req = "R5";
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 16);
            case (r)
                0: wr(3'd0, 32'($urandom % 1100));
                1: wr(3'd1, $urandom);
                2: wr(3'd2, 32'(int'($urandom % 41) - 20));
                3: wr(3'd3, 32'(int'($urandom % 19) - 9));
                4: wr(3'd4, $urandom);
                5: wr(3'd5, $urandom);
                6, 7, 8, 9: rd(3'($urandom % 8));
                default: idle(1 + int'($urandom % 15));
            endcase
        end
        finish_run();
    end

endmodule